// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block receives a stereo serial audio stream as a slave. The bit clock, the word-select clock and the serial data arrive already synchronous to the system clock. Each is sampled by `clk_i`, and the bit clock must stay at least one system clock in each level. At each rising edge of the bit clock the block samples the serial bit and the word-select level. It assembles left and right words under one of five framings: left justified, right justified, I2S, and the two pulse-framed DSP modes. It presents both words together with a single-cycle valid strobe.

The word length is selectable. Each received word is placed MSB-aligned in a 32-bit output, and the unused low bits are zero. In the three level-framed modes the block measures each word-select phase against the word length and pulses an error flag when a phase is too short. A separate flag reports a format and word-length pair that cannot be used. Format and word length are expected to change only while reset is asserted.

Top module: `aud_rx`

## Requirements
- R1: `wlen_i` selects the word length N: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. Words arrive MSB first. Each output word holds the N received bits in its top bits, and the lower 32-N bits are zero.
- R2: Left justified (`fmt_i` = 0). A high word-select level carries the left channel. The word's N bits start at the first bit-clock slot of the phase, and any later bits in that phase are discarded.
- R3: I2S (`fmt_i` = 2). A low word-select level carries the left channel. The word starts one slot after the word-select edge. When a phase is exactly N slots long, its last bit falls in the first slot of the next phase.
- R4: Right justified (`fmt_i` = 1). A high level carries the left channel. The word is the last N bits received before the edge that closes the phase.
- R5: DSP modes. A rising word-select edge marks the frame start. The left word starts one slot later in mode A (`fmt_i` = 3) and in the same slot in mode B (`fmt_i` = 4). The right word follows with no gap.
- R6: `valid_o` is high for exactly one clock after a right word completes, and only if a left word completed after the previous strobe. `left_o` and `right_o` change only in that clock.
- R7: In modes 0, 1 and 2, `frame_err_o` pulses for one clock when a word-select phase between two observed edges lasts fewer than N slots. It never pulses in the DSP modes.
- R8: A word-select duty cycle other than 50 % causes no error and no data loss, provided both phases last at least N slots.
- R9: `cfg_err_o` is high when `fmt_i` is 5 to 7, or when right justified is selected with 32-bit words. While it is high, no word is captured and `valid_o` stays low.
- R10: During reset all outputs are zero. The first bit-clock slot after reset only records the word-select level and is never treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| lrclk_i | input | 1 | Word-select clock |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 3 | Framing format select |
| wlen_i | input | 2 | Word length select |
| left_o | output | 32 | Left word, MSB aligned |
| right_o | output | 32 | Right word, MSB aligned |
| valid_o | output | 1 | Word pair strobe |
| frame_err_o | output | 1 | Short word-select phase pulse |
| cfg_err_o | output | 1 | Unsupported configuration |

## Verification
The assertions assume that the format and word length stay constant outside reset, and that the bit clock stays at least one system clock in each level, so that two slot ticks never fall on consecutive clocks. The bench changes format and word length only while reset is asserted. It drives every bit-clock level for two system clocks and changes data and word select only while the bit clock is low. Phase lengths are drawn at random from N to N+8 slots, with the exact minimum forced on the first frame of each run. Short phases and unusable configurations appear only in dedicated directed runs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned MAX_W = 32;
  localparam int unsigned CNT_W = $clog2(2 * MAX_W) + 1;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(20);
      2'd2:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_slot.sv
module aud_rx_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic tick_o,
  output logic edge_o,
  output logic rise_o
);
  logic bclk_q, lr_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (tick_o) begin
        lr_q  <= lrclk_i;
        vld_q <= 1'b1;
      end
    end
  end

  assign tick_o = bclk_i & ~bclk_q;
  // first slot after reset only sets the reference level
  assign edge_o = tick_o & vld_q & (lrclk_i ^ lr_q);
  assign rise_o = edge_o & lrclk_i;
endmodule

// File: rtl/aud_rx_width.sv
module aud_rx_width import aud_rx_pkg::*; #(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          edge_i,
  input  logic          chk_en_i,
  input  logic [CW-1:0] nbits_i,
  output logic          ferr_o
);
  logic [CW-1:0] plen_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plen_q <= '0;
      seen_q <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      ferr_o <= 1'b0;
      if (tick_i) begin
        if (edge_i) begin
          ferr_o <= chk_en_i & seen_q & (plen_q < nbits_i);
          seen_q <= 1'b1;
          plen_q <= CW'(1);
        end else if (plen_q != '1) begin
          plen_q <= plen_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aud_rx_cap.sv
module aud_rx_cap import aud_rx_pkg::*; #(
  parameter int unsigned W  = MAX_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          edge_i,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic          lr_i,
  input  logic          en_i,
  input  logic [2:0]    fmt_i,
  input  logic [CW-1:0] nbits_i,
  output logic          done_o,
  output logic          ch_o,
  output logic [W-1:0]  word_o
);
  logic          dsp, rj, off0, start, new_ch;
  logic [CW-1:0] nbits2;
  logic [W-1:0]  sh_q, sh_n, hist_q, hist_n, nxt, word_n, rj_mask;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n, ch_q, ch_n, done_n, wch_n;

  assign dsp     = (fmt_i == FMT_DSPA) || (fmt_i == FMT_DSPB);
  assign rj      = (fmt_i == FMT_RJ);
  assign off0    = (fmt_i == FMT_LJ) || (fmt_i == FMT_DSPB);
  assign start   = dsp ? rise_i : edge_i;
  assign new_ch  = (fmt_i == FMT_I2S) ? lr_i : ~lr_i;   // 1 = right
  assign nbits2  = {nbits_i[CW-2:0], 1'b0};
  assign nxt     = {sh_q[W-2:0], bit_i};
  assign rj_mask = ~({W{1'b1}} << nbits_i);

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    ch_n   = ch_q;
    hist_n = hist_q;
    done_n = 1'b0;
    wch_n  = 1'b0;
    word_n = '0;
    if (tick_i && en_i) begin
      hist_n = {hist_q[W-2:0], bit_i};
      if (rj) begin
        if (edge_i) begin
          done_n = 1'b1;
          word_n = hist_q & rj_mask;
          wch_n  = lr_i;                // closing phase was low
        end
      end else begin
        // running word takes the bit unless a zero-offset start claims it
        if (act_q && !(start && off0)) begin
          sh_n  = nxt;
          cnt_n = cnt_q + CW'(1);
          if (cnt_n == nbits_i || (dsp && cnt_n == nbits2)) begin
            done_n = 1'b1;
            word_n = nxt;
            wch_n  = ch_q;
            if (dsp && !ch_q) begin
              sh_n = '0;
              ch_n = 1'b1;
            end else begin
              act_n = 1'b0;
            end
          end
        end
        if (start) begin
          act_n = 1'b1;
          ch_n  = dsp ? 1'b0 : new_ch;
          sh_n  = off0 ? {{(W-1){1'b0}}, bit_i} : '0;
          cnt_n = off0 ? CW'(1) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      hist_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      ch_q   <= 1'b0;
      done_o <= 1'b0;
      ch_o   <= 1'b0;
      word_o <= '0;
    end else begin
      sh_q   <= sh_n;
      hist_q <= hist_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      ch_q   <= ch_n;
      done_o <= done_n;
      ch_o   <= wch_n;
      word_o <= word_n;
    end
  end
endmodule

// File: rtl/aud_rx.sv
module aud_rx import aud_rx_pkg::*; #(
  parameter int unsigned W = MAX_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic         lrclk_i,
  input  logic         sdata_i,
  input  logic [2:0]   fmt_i,
  input  logic [1:0]   wlen_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o,
  output logic         frame_err_o,
  output logic         cfg_err_o
);
  localparam int unsigned CW = CNT_W;
  localparam logic [CW-1:0] W_C = CW'(W);

  logic          tick, lr_edge, lr_rise, en, dsp;
  logic          done, done_ch;
  logic [W-1:0]  word, word_al, left_hold;
  logic          left_ok;
  logic [CW-1:0] nbits;

  assign nbits     = word_bits(wlen_i);
  assign cfg_err_o = (fmt_i > 3'd4) || ((fmt_i == FMT_RJ) && (wlen_i == 2'd3));
  assign en        = ~cfg_err_o;
  assign dsp       = (fmt_i == FMT_DSPA) || (fmt_i == FMT_DSPB);
  assign word_al   = word << (W_C - nbits);

  aud_rx_slot u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .lrclk_i(lrclk_i),
    .tick_o (tick),
    .edge_o (lr_edge),
    .rise_o (lr_rise)
  );

  aud_rx_width #(.CW(CW)) u_width (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .edge_i  (lr_edge),
    .chk_en_i(en & ~dsp),
    .nbits_i (nbits),
    .ferr_o  (frame_err_o)
  );

  aud_rx_cap #(.W(W), .CW(CW)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .edge_i (lr_edge),
    .rise_i (lr_rise),
    .bit_i  (sdata_i),
    .lr_i   (lrclk_i),
    .en_i   (en),
    .fmt_i  (fmt_i),
    .nbits_i(nbits),
    .done_o (done),
    .ch_o   (done_ch),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done) begin
        if (!done_ch) begin
          left_hold <= word_al;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_o  <= left_hold;
          right_o <= word_al;
          valid_o <= 1'b1;
          left_ok <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   fmt_i,
  input logic [1:0]   wlen_i,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o,
  input logic         frame_err_o,
  input logic         cfg_err_o
);
  logic [W-1:0] pad_mask;
  logic         is_dsp;

  always_comb begin
    case (wlen_i)
      2'd0:    pad_mask = ~({W{1'b1}} << (W - 16));
      2'd1:    pad_mask = ~({W{1'b1}} << (W - 20));
      2'd2:    pad_mask = ~({W{1'b1}} << (W - 24));
      default: pad_mask = ~({W{1'b1}} << (W - 32));
    endcase
  end
  assign is_dsp = (fmt_i == 3'd3) || (fmt_i == 3'd4);

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  p_pad_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $stable(wlen_i)) |->
      (((left_o & pad_mask) == '0) && ((right_o & pad_mask) == '0)));

  p_ferr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  p_dsp_no_ferr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_dsp && $stable(fmt_i)) |-> !frame_err_o);

  p_cfg_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cfg_err_o) && $past(cfg_err_o, 2)) |-> !valid_o);
endmodule

bind aud_rx aud_rx_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fmt_i      (fmt_i),
  .wlen_i     (wlen_i),
  .left_o     (left_o),
  .right_o    (right_o),
  .valid_o    (valid_o),
  .frame_err_o(frame_err_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/sim_aud_rx.sv
module sim_aud_rx;
  localparam int W = 32;
  localparam int DEPTH = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [1:0] wlen = 2'd0;
  logic [W-1:0] left_o, right_o;
  logic valid_o, frame_err_o, cfg_err_o;

  always #10 clk = ~clk;

  aud_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .fmt_i(fmt), .wlen_i(wlen), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o), .cfg_err_o(cfg_err_o)
  );

  int errs = 0, checks = 0;
  logic lr_a [DEPTH];
  logic sd_a [DEPTH];
  logic [W-1:0] exp_l [64];
  logic [W-1:0] exp_r [64];
  int wp, ne, nrd, vcnt, fcnt;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string tag;

  function automatic int nb(input logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 20; 2'd2: return 24; default: return 32; endcase
  endfunction
  function automatic logic [W-1:0] msk(input int n);
    return (W'(1) << n) - W'(1);
  endfunction
  function automatic logic [W-1:0] algn(input logic [W-1:0] v, input int n);
    return v << (W - n);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err_o) fcnt++;
      if (valid_o) begin
        vcnt++;
        if (cmp_on) begin
          if (nrd < ne) begin
            check(left_o == exp_l[nrd], tag, "left word R1", left_o, exp_l[nrd]);
            check(right_o == exp_r[nrd], tag, "right word R1", right_o, exp_r[nrd]);
            nrd++;
          end else check(1'b0, "R6", "unexpected strobe", vcnt, ne);
        end
      end
    end
  end

  task automatic start_run(input logic [2:0] f, input logic [1:0] w);
    rst_n = 1'b0;
    fmt = f; wlen = w; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      sd_a[i] = 1'($urandom % 2);
      lr_a[i] = 1'b0;
    end
    wp = 0; ne = 0; nrd = 0;
    repeat (3) @(negedge clk);
    vcnt = 0; fcnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_lr(input logic lvl, input int len);
    for (int i = 0; i < len; i++) lr_a[wp + i] = lvl;
    wp += len;
  endtask

  task automatic place(input int pos, input logic [W-1:0] v, input int n);
    for (int k = 0; k < n; k++) sd_a[pos + k] = v[n - 1 - k];
  endtask

  function automatic logic left_lvl(input logic [2:0] f);
    return (f == 3'd2) ? 1'b0 : 1'b1;
  endfunction

  task automatic add_frame(input logic [2:0] f, input int n, input int pl, input int pr);
    logic [W-1:0] l, r;
    int s1, s2;
    l = W'($urandom) & msk(n);
    r = W'($urandom) & msk(n);
    s1 = wp; set_lr(left_lvl(f), pl);
    s2 = wp; set_lr(~left_lvl(f), pr);
    case (f)
      3'd0: begin place(s1, l, n); place(s2, r, n); end
      3'd1: begin place(s1 + pl - n, l, n); place(s2 + pr - n, r, n); end
      default: begin place(s1 + 1, l, n); place(s2 + 1, r, n); end
    endcase
    exp_l[ne] = algn(l, n); exp_r[ne] = algn(r, n); ne++;
  endtask

  task automatic add_dsp(input logic [2:0] f, input int n, input int extra);
    logic [W-1:0] l, r;
    int s, off;
    off = (f == 3'd3) ? 1 : 0;
    l = W'($urandom) & msk(n);
    r = W'($urandom) & msk(n);
    s = wp;
    set_lr(1'b1, 1);
    set_lr(1'b0, 2 * n + off - 1 + extra);
    place(s + off, l, n);
    place(s + off + n, r, n);
    exp_l[ne] = algn(l, n); exp_r[ne] = algn(r, n); ne++;
  endtask

  task automatic play();
    for (int i = 0; i < wp; i++) begin
      lrclk = lr_a[i]; sdata = sd_a[i]; bclk = 1'b0;
      repeat (2) @(negedge clk);
      bclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    bclk = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(left_o == '0 && right_o == '0, "R10", "reset words", {left_o, right_o}, 0);
    check(!valid_o && !frame_err_o, "R10", "reset strobes", {valid_o, frame_err_o}, 0);

    // main function per format and length
    for (int f = 0; f < 5; f++) begin
      for (int w = 0; w < 4; w++) begin
        int n;
        if (f == 1 && w == 3) continue;
        n = nb(2'(w));
        case (f) 0: tag = "R2"; 1: tag = "R4"; 2: tag = "R3"; default: tag = "R5"; endcase
        start_run(3'(f), 2'(w));
        cmp_on = 1'b1;
        if (f >= 3) begin
          set_lr(1'b0, 8);
          for (int k = 0; k < 5; k++) add_dsp(3'(f), n, (k == 0) ? 0 : int'($urandom % 5));
          set_lr(1'b0, 8);
        end else begin
          set_lr(~left_lvl(3'(f)), 40);
          add_frame(3'(f), n, n, n);   // minimum phases
          for (int k = 0; k < 4; k++)
            add_frame(3'(f), n, n + int'($urandom % 9), n + int'($urandom % 9));  // R8 uneven duty
          set_lr(left_lvl(3'(f)), 40);
        end
        play();
        check(vcnt == ne, tag, "R6 strobe count", vcnt, ne);
        check(fcnt == 0, (f >= 3) ? "R7" : "R8", "no frame error", fcnt, 0);
      end
    end
    cmp_on = 1'b0;

    // short phase in each level-framed mode
    for (int f = 0; f < 3; f++) begin
      start_run(3'(f), 2'd0);
      set_lr(~left_lvl(3'(f)), 40);
      add_frame(3'(f), 16, 16, 16);
      set_lr(left_lvl(3'(f)), 10);
      set_lr(~left_lvl(3'(f)), 20);
      set_lr(left_lvl(3'(f)), 20);
      set_lr(~left_lvl(3'(f)), 40);
      play();
      check(fcnt == 1, "R7", "short phase error count", fcnt, 1);
    end

    // unusable configurations
    start_run(3'd1, 2'd3);
    check(cfg_err_o == 1'b1, "R9", "rj 32-bit flag", cfg_err_o, 1);
    set_lr(1'b0, 40);
    for (int k = 0; k < 3; k++) begin set_lr(1'b1, 34); set_lr(1'b0, 34); end
    set_lr(1'b1, 40);
    play();
    check(vcnt == 0, "R9", "no strobe when unsupported", vcnt, 0);
    start_run(3'd6, 2'd0);
    check(cfg_err_o == 1'b1, "R9", "bad format flag", cfg_err_o, 1);
    start_run(3'd1, 2'd2);
    check(cfg_err_o == 1'b0, "R9", "rj 24-bit flag", cfg_err_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R6 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule